// File: doc/BRIEF.md
# Two-Stage Frequency Acquisition Controller

This block is the digital side of a frequency-locked loop that steers an oscillator through a 7-bit DAC code. It runs in two stages. After reset it starts from the lowest code, which is by design below the wanted frequency. In the coarse stage it raises the code one step for each rising data transition that arrives while the coarse detector says the oscillator is too slow. Once the detector has stayed quiet for a fixed run of data transitions, coarse lock is declared and the block moves to the fine stage. It never returns to the coarse stage.

In the fine stage, separate up and down pulses from a fine detector nudge an internal accumulator. The gain in this stage is 1/128 of the coarse gain, chosen by a shift. A fixed number of unit-interval ticks with no up or down pulse declares fine lock. After that the fine loop keeps correcting. The accumulator clamps at both ends of its range and does not wrap. Its low bits are dropped, and a first-order delta-sigma modulator turns the remaining value into the 7-bit code. The time average of that code therefore carries the dropped fraction.

Top module: `fll_freq_ctrl`

## Requirements
- R1: While `rst_n` is low, `dac_code` is 0, `stage` is 0 (idle), and both `coarse_lock` and `fine_lock` are 0.
- R2: Reset release is synchronised through two flops. `stage` stays 0 for the first two rising edges after release and becomes 1 (coarse) on the third.
- R3: In the coarse stage, a cycle with `data_rise`=1 and `coarse_up`=1 adds 2048 to the 18-bit accumulator, which is one DAC code step. `coarse_up` without `data_rise` changes nothing. The code never falls during the coarse stage.
- R4: A cycle with `data_rise`=1 and `coarse_up`=0 counts as a quiet transition, and a stepping transition restarts the count. On the edge that counts the 1024th consecutive quiet transition, `stage` becomes 2 (fine) and `coarse_lock` becomes 1. Both then hold until reset.
- R5: In the fine stage, `fine_up` alone adds 16 and `fine_dn` alone subtracts 16. Both together, or neither, leave the accumulator unchanged. The coarse inputs are ignored in the fine stage, and the fine inputs are ignored in the coarse stage.
- R6: The top 14 bits T of the accumulator feed a first-order modulator with a 7-bit residue r. Each edge, s = r + T[6:0]; the new code is min(127, T[13:7] + s[7]); r becomes s[6:0]. The modulator reads the accumulator one edge after it changes. Over 128 cycles of constant T, the code sums to 128*T[13:7] + T[6:0]. The code never moves by more than 1 per cycle.
- R7: The accumulator saturates at 0 and at 262143 instead of wrapping. At the maximum, the code stays at 127.
- R8: In the fine stage, a cycle with `ui_tick`=1 and no fine pulse is counted, and any fine pulse restarts the count. On the edge that counts the 1024th such tick, `fine_lock` becomes 1. It then holds until reset while fine correction goes on.
- R9: `stage` takes only the values 0 (idle), 1 (coarse) and 2 (fine).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| data_rise | input | 1 | One-cycle marker of a rising data transition |
| coarse_up | input | 1 | Coarse detector: oscillator below target |
| fine_up | input | 1 | Fine detector: raise frequency |
| fine_dn | input | 1 | Fine detector: lower frequency |
| ui_tick | input | 1 | One-cycle marker per unit interval |
| dac_code | output | 7 | Modulated oscillator DAC code |
| stage | output | 2 | 0 idle, 1 coarse, 2 fine |
| coarse_lock | output | 1 | Coarse stage finished |
| fine_lock | output | 1 | Fine quiet period reached |

## Verification
The stage and lock flags change on the same edge that samples the qualifying transition or tick. The accumulator changes on the edge of the step, and `dac_code` reflects it one edge later. The stage leaves idle on the third edge after reset release. The bench drives inputs just after a falling edge, lets a behavioural model advance on the rising edge, and compares every output at the next falling edge. Average-code checks therefore start one idle cycle after the last accumulator change, so that the whole 128-cycle window sees a constant value.

// File: rtl/fll_ctrl_pkg.sv
package fll_ctrl_pkg;
  typedef enum logic [1:0] {
    STG_IDLE   = 2'd0,
    STG_COARSE = 2'd1,
    STG_FINE   = 2'd2
  } stage_e;
endpackage

// File: rtl/fll_quiet_count.sv
// Counts qualifying events without interruption; hit_o marks the event that
// completes the run of LIMIT. Saturates at LIMIT until cleared.
module fll_quiet_count #(
  parameter int LIMIT = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic inc_i,
  output logic hit_o
);
  localparam int CW = $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr_i || (inc_i && (cnt_q != CW'(LIMIT)));
    if (clr_i) cnt_d = '0;
    else       cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign hit_o = inc_i && !clr_i && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/fll_loop_accum.sv
// Saturating integrator with shift-selected gain; emits the value with the
// DROP_W least significant bits removed.
module fll_loop_accum #(
  parameter int ACC_W      = 18,
  parameter int DROP_W     = 4,
  parameter int STEP_LOG2  = 11,
  parameter int FINE_SHIFT = 7
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    coarse_inc_i,
  input  logic                    fine_inc_i,
  input  logic                    fine_dec_i,
  output logic [ACC_W-DROP_W-1:0] trunc_o
);
  localparam logic [ACC_W-1:0] COARSE_STEP = ACC_W'(1) << STEP_LOG2;
  localparam logic [ACC_W-1:0] FINE_STEP   = COARSE_STEP >> FINE_SHIFT;
  localparam logic [ACC_W-1:0] ACC_MAX     = {ACC_W{1'b1}};

  logic [ACC_W-1:0] acc_q, acc_d, step_mag;
  logic [ACC_W:0]   sum_ext;
  logic             do_add, do_sub, acc_en;

  always_comb begin
    step_mag = coarse_inc_i ? COARSE_STEP : FINE_STEP;
    do_add   = coarse_inc_i || fine_inc_i;
    do_sub   = fine_dec_i && !coarse_inc_i;
    acc_en   = do_add || do_sub;
    sum_ext  = {1'b0, acc_q} + {1'b0, step_mag};
    if (do_add)                acc_d = sum_ext[ACC_W] ? ACC_MAX : sum_ext[ACC_W-1:0];
    else if (acc_q < step_mag) acc_d = '0;
    else                       acc_d = acc_q - step_mag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      acc_q <= '0;
    else if (acc_en) acc_q <= acc_d;
  end

  assign trunc_o = acc_q[ACC_W-1:DROP_W];
endmodule

// File: rtl/fll_dsm1.sv
// First-order modulator: integer part plus carry of the running fraction.
module fll_dsm1 #(
  parameter int IN_W  = 14,
  parameter int OUT_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IN_W-1:0]  val_i,
  output logic [OUT_W-1:0] code_o
);
  localparam int FRAC_W = IN_W - OUT_W;

  logic [OUT_W-1:0] code_q, code_d;

  generate
    if (FRAC_W > 0) begin : g_mod
      logic [FRAC_W-1:0] res_q;
      logic [FRAC_W:0]   frac_sum;
      logic [OUT_W:0]    int_sum;

      always_comb begin
        frac_sum = {1'b0, res_q} + {1'b0, val_i[FRAC_W-1:0]};
        int_sum  = {1'b0, val_i[IN_W-1:FRAC_W]} + {{OUT_W{1'b0}}, frac_sum[FRAC_W]};
        code_d   = int_sum[OUT_W] ? {OUT_W{1'b1}} : int_sum[OUT_W-1:0];
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= frac_sum[FRAC_W-1:0];
      end
    end else begin : g_pass
      always_comb code_d = val_i[OUT_W-1:0];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) code_q <= '0;
    else        code_q <= code_d;
  end

  assign code_o = code_q;
endmodule

// File: rtl/fll_freq_ctrl.sv
module fll_freq_ctrl
  import fll_ctrl_pkg::*;
#(
  parameter int ACC_W      = 18,
  parameter int DROP_W     = 4,
  parameter int DAC_W      = 7,
  parameter int STEP_LOG2  = 11,
  parameter int FINE_SHIFT = 7,
  parameter int QUIET_LEN  = 1024
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             data_rise,
  input  logic             coarse_up,
  input  logic             fine_up,
  input  logic             fine_dn,
  input  logic             ui_tick,
  output logic [DAC_W-1:0] dac_code,
  output logic [1:0]       stage,
  output logic             coarse_lock,
  output logic             fine_lock
);
  localparam int TRUNC_W = ACC_W - DROP_W;

  // reset: asserted asynchronously, released after two edges
  logic [1:0] rst_pipe_q;
  logic       rst_sn;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sn = rst_pipe_q[1];

  stage_e stage_q, stage_d;
  logic   coarse_mode, fine_mode;
  logic   coarse_step, coarse_quiet, coarse_hit;
  logic   fine_pulse, fine_hit;
  logic   fine_lock_q, fine_lock_en;
  logic [TRUNC_W-1:0] trunc_val;

  always_comb begin
    coarse_mode  = (stage_q == STG_COARSE);
    fine_mode    = (stage_q == STG_FINE);
    coarse_step  = coarse_mode && data_rise && coarse_up;
    coarse_quiet = coarse_mode && data_rise && !coarse_up;
    fine_pulse   = fine_up || fine_dn;
  end

  always_comb begin
    stage_d = stage_q;
    case (stage_q)
      STG_IDLE:   stage_d = STG_COARSE;
      STG_COARSE: if (coarse_hit) stage_d = STG_FINE;
      STG_FINE:   stage_d = STG_FINE;
      default:    stage_d = STG_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) stage_q <= STG_IDLE;
    else         stage_q <= stage_d;
  end

  fll_quiet_count #(.LIMIT(QUIET_LEN)) u_coarse_quiet (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr_i (!coarse_mode || coarse_step),
    .inc_i (coarse_quiet),
    .hit_o (coarse_hit)
  );

  fll_quiet_count #(.LIMIT(QUIET_LEN)) u_fine_quiet (
    .clk   (clk),
    .rst_n (rst_sn),
    .clr_i (!fine_mode || fine_pulse),
    .inc_i (fine_mode && ui_tick),
    .hit_o (fine_hit)
  );

  assign fine_lock_en = fine_hit;

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)           fine_lock_q <= 1'b0;
    else if (fine_lock_en) fine_lock_q <= 1'b1;
  end

  fll_loop_accum #(
    .ACC_W      (ACC_W),
    .DROP_W     (DROP_W),
    .STEP_LOG2  (STEP_LOG2),
    .FINE_SHIFT (FINE_SHIFT)
  ) u_accum (
    .clk          (clk),
    .rst_n        (rst_sn),
    .coarse_inc_i (coarse_step),
    .fine_inc_i   (fine_mode && fine_up && !fine_dn),
    .fine_dec_i   (fine_mode && fine_dn && !fine_up),
    .trunc_o      (trunc_val)
  );

  fll_dsm1 #(.IN_W(TRUNC_W), .OUT_W(DAC_W)) u_dsm (
    .clk    (clk),
    .rst_n  (rst_sn),
    .val_i  (trunc_val),
    .code_o (dac_code)
  );

  assign stage       = stage_q;
  assign coarse_lock = fine_mode;
  assign fine_lock   = fine_lock_q;
endmodule

// File: rtl/fll_freq_ctrl_chk.sv
module fll_freq_ctrl_chk #(
  parameter int DAC_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       stage,
  input logic [DAC_W-1:0] dac_code,
  input logic             coarse_lock,
  input logic             fine_lock
);
  AST_STAGE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n) stage != 2'b11); // R9
  AST_CODE_STEP_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
    ((dac_code > $past(dac_code)) ? (dac_code - $past(dac_code)) : ($past(dac_code) - dac_code)) <= 1); // R6
  AST_COARSE_MONOTONE: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd1) |=> (dac_code >= $past(dac_code))); // R3
  AST_FINE_ONE_WAY: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd2) |=> (stage == 2'd2 && coarse_lock)); // R4
  AST_FINE_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    fine_lock |=> fine_lock); // R8
  AST_FINE_LOCK_IN_FINE: assert property (@(posedge clk) disable iff (!rst_n)
    fine_lock |-> (stage == 2'd2)); // R8
  AST_IDLE_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (stage == 2'd0) |-> (!coarse_lock && !fine_lock)); // R1
endmodule

bind fll_freq_ctrl fll_freq_ctrl_chk #(.DAC_W(DAC_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .stage       (stage),
  .dac_code    (dac_code),
  .coarse_lock (coarse_lock),
  .fine_lock   (fine_lock)
);

// File: tb/fll_freq_ctrl_tb_top.sv
`timescale 1ns/1ps
module fll_freq_ctrl_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n, dr, cu, fu, fd, ut;
  logic [6:0] dac_code;
  logic [1:0] stage;
  logic coarse_lock, fine_lock;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  fll_freq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .data_rise(dr), .coarse_up(cu),
    .fine_up(fu), .fine_dn(fd), .ui_tick(ut), .dac_code(dac_code),
    .stage(stage), .coarse_lock(coarse_lock), .fine_lock(fine_lock)
  );

  // behavioural reference
  int m_s0, m_s1, m_stage, m_acc, m_res, m_code, m_cq, m_fq, m_flock;
  always @(posedge clk) begin
    int t, s, c;
    if (!rst_n) begin
      m_s0 = 0; m_s1 = 0; m_stage = 0; m_acc = 0; m_res = 0;
      m_code = 0; m_cq = 0; m_fq = 0; m_flock = 0;
    end else begin
      if (m_s1 == 1) begin
        t = m_acc / 16;
        s = m_res + (t % 128);
        c = t / 128 + s / 128;
        m_code = (c > 127) ? 127 : c;
        m_res = s % 128;
        if (m_stage == 0) m_stage = 1;
        else if (m_stage == 1) begin
          if (dr) begin
            if (cu) begin
              m_acc = (m_acc + 2048 > 262143) ? 262143 : m_acc + 2048;
              m_cq = 0;
            end else begin
              if (m_cq == 1023) m_stage = 2;
              if (m_cq < 1024) m_cq++;
            end
          end
        end else begin
          if (fu && !fd) m_acc = (m_acc + 16 > 262143) ? 262143 : m_acc + 16;
          else if (fd && !fu) m_acc = (m_acc < 16) ? 0 : m_acc - 16;
          if (fu || fd) m_fq = 0;
          else if (ut) begin
            if (m_fq == 1023) m_flock = 1;
            if (m_fq < 1024) m_fq++;
          end
        end
      end
      m_s1 = m_s0; m_s0 = 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic a, input logic b, input logic c, input logic d, input logic e);
    dr = a; cu = b; fu = c; fd = d; ut = e;
    @(posedge clk);
    @(negedge clk);
    chk(dac_code == m_code, "R6 dac_code vs model", dac_code, m_code);
    chk(stage == m_stage, "R9 stage vs model", stage, m_stage);
    chk(coarse_lock == (m_stage == 2), "R4 coarse_lock vs model", coarse_lock, m_stage == 2);
    chk(fine_lock == m_flock, "R8 fine_lock vs model", fine_lock, m_flock);
  endtask

  task automatic idle_sum(output int s);
    s = 0;
    for (int i = 0; i < 128; i++) begin
      cyc(0, 0, 0, 0, 0);
      s += dac_code;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; dr = 0; cu = 0; fu = 0; fd = 0; ut = 0;
    @(negedge clk); @(negedge clk);
    chk(stage == 0, "R1 stage in reset", stage, 0);
    chk(dac_code == 0, "R1 code in reset", dac_code, 0);
    chk(!coarse_lock && !fine_lock, "R1 locks in reset", {coarse_lock, fine_lock}, 0);
    rst_n = 1;
    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    chk(stage == 0, "R2 stage idle two edges after release", stage, 0);
    cyc(0, 0, 0, 0, 0);
    chk(stage == 1, "R2 stage coarse on third edge", stage, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int s;
    rst_n = 0; dr = 0; cu = 0; fu = 0; fd = 0; ut = 0;
    do_reset();
    // R3 coarse ramp, up without rise does nothing
    for (int i = 0; i < 40; i++) begin cyc(1, 1, 0, 0, 0); cyc(0, 1, 0, 0, 0); end
    cyc(0, 0, 0, 0, 0);
    chk(dac_code == 40, "R3 code after 40 steps", dac_code, 40);
    // R5 fine inputs ignored in coarse
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 1, 0); cyc(0, 0, 0, 0, 0);
    chk(dac_code == 40, "R5 fine pulses ignored in coarse", dac_code, 40);
    // R4 quiet run restarted by a step
    for (int i = 0; i < 500; i++) cyc(1, 0, 0, 0, 0);
    cyc(1, 1, 0, 0, 0);
    for (int i = 0; i < 1023; i++) cyc(1, 0, 0, 0, 0);
    chk(stage == 1 && !coarse_lock, "R4 no lock at 1023 quiet", stage, 1);
    cyc(1, 0, 0, 0, 0);
    chk(stage == 2, "R4 fine stage at 1024th quiet", stage, 2);
    chk(coarse_lock == 1, "R4 coarse_lock set", coarse_lock, 1);
    // R5 coarse inputs ignored in fine, then fine gain
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 0);
    for (int i = 0; i < 10; i++) cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    idle_sum(s);
    chk(s == 5258, "R6 code sum over 128 cycles", s, 5258);
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 1, 0);
    for (int i = 0; i < 2; i++) cyc(0, 0, 1, 1, 0);
    cyc(0, 0, 0, 0, 0);
    idle_sum(s);
    chk(s == 5255, "R5 down and both-pulse handling", s, 5255);
    // R8 fine lock
    for (int i = 0; i < 700; i++) cyc(0, 0, 0, 0, 1);
    cyc(0, 0, 1, 0, 0);
    for (int i = 0; i < 1023; i++) cyc(0, 0, 0, 0, 1);
    chk(fine_lock == 0, "R8 no lock at 1023 ticks", fine_lock, 0);
    cyc(0, 0, 0, 0, 1);
    chk(fine_lock == 1, "R8 lock at 1024th tick", fine_lock, 1);
    cyc(0, 0, 0, 1, 0);
    chk(fine_lock == 1, "R8 lock holds after pulse", fine_lock, 1);
    // R7 floor
    for (int i = 0; i < 6000; i++) cyc(0, 0, 0, 1, 0);
    cyc(0, 0, 0, 0, 0); cyc(0, 0, 0, 0, 0);
    chk(dac_code == 0, "R7 code at floor", dac_code, 0);
    cyc(0, 0, 1, 0, 0); cyc(0, 0, 0, 0, 0);
    idle_sum(s);
    chk(s == 1, "R7 no wrap below zero", s, 1);
    // R7 ceiling
    do_reset();
    for (int i = 0; i < 130; i++) cyc(1, 1, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    chk(dac_code == 127, "R7 code at ceiling", dac_code, 127);
    for (int i = 0; i < 1024; i++) cyc(1, 0, 0, 0, 0);
    chk(stage == 2, "R4 fine stage after ceiling", stage, 2);
    for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    idle_sum(s);
    chk(s == 16256, "R7 no wrap above maximum", s, 16256);
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule